// File: doc/BRIEF.md
# Multi-flow NoC traffic generator

This block injects packets into one terminal of a network-on-chip on behalf of several independently configured communication flows. Each flow has a slot holding its descriptor (bandwidth tag, flow id, reserved protocol field, destination address, remaining packet count, packet size, idle gap) and a next-send timestamp. A global cycle counter runs from zero once configuration ends. A flow asks for service when that counter has reached its timestamp and it still has packets left. A round-robin arbiter hands one requesting flow at a time to a shared packet engine. The engine writes the header, payload and trailer flits into a small FIFO that drives the network link with a valid/ready handshake.

The descriptors of all flows form one serial shift register. Many generators can be daisy-chained by wiring the serial output of one to the serial input of the next. Shifting clears the cycle counter and all timestamps. When shifting stops, the experiment starts. Every trailer carries the timestamp at which its packet was due, so a receiver can measure latency.

Top module: `noc_traffic_gen`

## Requirements
- R1: The cycle counter is 0 after reset and is cleared on every clock while `cfg_shift_en` is high. Otherwise it increments by one on every clock.
- R2: While `cfg_shift_en` is high, the descriptor chain shifts one bit per clock from `cfg_sin`. `cfg_sout` shows the bit that entered NUM_FLOWS*70 clocks earlier and is 0 after reset. The stream carries flow 0 first. Each flow's descriptor is sent most significant bit first with these fields: bandwidth (7 bits), flow id (4), protocol (9), destination (8), packet count (20), size in flits (10), idle gap (12).
- R3: A flow requests service only while `cfg_shift_en` is low, its packet count is non-zero and the cycle counter is at least its next-send timestamp. Shifting resets every timestamp to 0 and produces no link traffic.
- R4: The arbiter grants one requesting flow per packet, searching from the flow after the last one granted (flow 0 has priority after reset). A new grant can be made on the cycle after the previous packet's trailer enters the FIFO.
- R5: The header flit has `link_bop`=1 and `link_eop`=0. Its fields are: destination in bits 31:24, source address `SRC_ADDR` in bits 23:16, bandwidth in bits 15:9, flow id in bits 8:5, and zero in bits 4:0.
- R6: A packet has max(size,2) flits: the header, then max(size,2)-2 payload flits, then the trailer. Payload flit j (counting from 1) carries the protocol field in bits 31:23 and j in bits 9:0, with zeros elsewhere and both markers low.
- R7: The trailer flit has `link_eop`=1 and `link_bop`=0 and carries the flow's next-send timestamp as it was when the packet was granted.
- R8: When a packet's trailer enters the FIFO, the flow's timestamp is advanced by max(size,2) plus the gap and its count is decremented. A flow whose count is 0 sends nothing more.
- R9: `link_valid` is 0 after reset. While `link_valid` is high and `link_ready` is low, `link_valid`, `link_data`, `link_bop` and `link_eop` hold their values. Flits leave in the order they were built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift the descriptor chain; holds the experiment stopped |
| cfg_sin | input | 1 | Serial configuration input |
| cfg_sout | output | 1 | Serial configuration output to the next generator |
| link_valid | output | 1 | Flit available on the link |
| link_ready | input | 1 | Network accepts the flit |
| link_data | output | 32 | Flit payload |
| link_bop | output | 1 | Flit begins a packet |
| link_eop | output | 1 | Flit ends a packet |

## Verification
Two situations are hard to reach from the ports. The first is a grant at a moment when some flows are ready and others are still waiting on their timestamps, so that round-robin order and timestamp gating act together. The bench sets up this case by giving the flows different sizes and gaps, including one that is clamped to two flits. With the link always ready, the engine's timing is fixed, so a behavioural time-stepped model can predict the exact packet order and every trailer timestamp. Backpressure that fills the FIFO is tested with a single active flow under a pseudo-random ready pattern. The serial read-back is tested by shifting a second image straight behind the first and comparing the bits that come out.

// File: rtl/ntg_pkg.sv
package ntg_pkg;

    localparam int ADDR_W  = 8;
    localparam int PROTO_W = 9;
    localparam int BW_W    = 7;
    localparam int FID_W   = 4;
    localparam int TIME_W  = 32;
    localparam int COUNT_W = 20;
    localparam int SIZE_W  = 10;
    localparam int GAP_W   = 12;
    localparam int FLIT_W  = 32;

    // Serial descriptor image of one flow, most significant field first.
    typedef struct packed {
        logic [BW_W-1:0]    bw;
        logic [FID_W-1:0]   fid;
        logic [PROTO_W-1:0] proto;
        logic [ADDR_W-1:0]  dest;
        logic [COUNT_W-1:0] count;
        logic [SIZE_W-1:0]  size;
        logic [GAP_W-1:0]   gap;
    } flow_desc_t;

    localparam int DESC_W  = $bits(flow_desc_t);
    localparam int HDR_PAD = FLIT_W - 2*ADDR_W - BW_W - FID_W;
    localparam int PAY_PAD = FLIT_W - PROTO_W - SIZE_W;

    // Fields the packet engine needs from the granted flow.
    typedef struct packed {
        logic [BW_W-1:0]    bw;
        logic [FID_W-1:0]   fid;
        logic [PROTO_W-1:0] proto;
        logic [ADDR_W-1:0]  dest;
        logic [SIZE_W-1:0]  size;
    } pkt_info_t;

    typedef struct packed {
        logic              bop;
        logic              eop;
        logic [FLIT_W-1:0] data;
    } flit_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_HEAD,
        ENG_BODY,
        ENG_TAIL
    } eng_state_t;

    function automatic logic [SIZE_W-1:0] eff_size(input logic [SIZE_W-1:0] s);
        return (s < SIZE_W'(2)) ? SIZE_W'(2) : s;
    endfunction

    function automatic logic [FLIT_W-1:0] make_header(
        input logic [ADDR_W-1:0] dest,
        input logic [ADDR_W-1:0] src,
        input logic [BW_W-1:0]   bw,
        input logic [FID_W-1:0]  fid
    );
        return {dest, src, bw, fid, {HDR_PAD{1'b0}}};
    endfunction

    function automatic logic [FLIT_W-1:0] make_payload(
        input logic [PROTO_W-1:0] proto,
        input logic [SIZE_W-1:0]  idx
    );
        return {proto, {PAY_PAD{1'b0}}, idx};
    endfunction

endpackage

// File: rtl/ntg_flow_slot.sv
module ntg_flow_slot
    import ntg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              sin,
    output logic              sout,
    input  logic [TIME_W-1:0] gcc,
    input  logic              done,
    output logic              req,
    output logic [TIME_W-1:0] stamp,
    output pkt_info_t         info
);

    flow_desc_t        desc_q;
    logic [TIME_W-1:0] nsc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
            nsc_q  <= '0;
        end else if (shift_en) begin
            desc_q <= flow_desc_t'({desc_q[DESC_W-2:0], sin});
            nsc_q  <= '0;
        end else if (done) begin
            nsc_q <= nsc_q + TIME_W'(eff_size(desc_q.size)) + TIME_W'(desc_q.gap);
            if (desc_q.count != '0) begin
                desc_q.count <= desc_q.count - 1'b1;
            end
        end
    end

    assign sout  = desc_q[DESC_W-1];
    assign req   = !shift_en && (desc_q.count != '0) && (gcc >= nsc_q);
    assign stamp = nsc_q;

    always_comb begin
        info.bw    = desc_q.bw;
        info.fid   = desc_q.fid;
        info.proto = desc_q.proto;
        info.dest  = desc_q.dest;
        info.size  = desc_q.size;
    end

endmodule

// File: rtl/ntg_rr_arbiter.sv
module ntg_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);

    logic [IW-1:0] last_q;
    int            cand;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        cand      = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last_q) + k) % N;
            if (!any && req[cand]) begin
                any         = 1'b1;
                grant[cand] = 1'b1;
                grant_idx   = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N-1);
        end else if (advance) begin
            last_q <= grant_idx;
        end
    end

endmodule

// File: rtl/ntg_pkt_engine.sv
module ntg_pkt_engine
    import ntg_pkg::*;
#(
    parameter int                N        = 4,
    parameter int                IW       = 2,
    parameter logic [ADDR_W-1:0] SRC_ADDR = 8'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_req,
    input  logic [IW-1:0]     sel_idx,
    input  pkt_info_t         sel_info,
    input  logic [TIME_W-1:0] sel_stamp,
    input  logic              fifo_full,
    output logic              accept,
    output logic              push,
    output flit_t             push_flit,
    output logic [N-1:0]      done_vec
);

    eng_state_t        state_q;
    logic [IW-1:0]     flow_q;
    pkt_info_t         info_q;
    logic [TIME_W-1:0] stamp_q;
    logic [SIZE_W-1:0] left_q;
    logic [SIZE_W-1:0] seq_q;

    always_comb begin
        accept    = 1'b0;
        push      = 1'b0;
        push_flit = '0;
        done_vec  = '0;
        case (state_q)
            ENG_IDLE: begin
                accept = any_req;
            end
            ENG_HEAD: begin
                push           = !fifo_full;
                push_flit.bop  = 1'b1;
                push_flit.data = make_header(info_q.dest, SRC_ADDR, info_q.bw, info_q.fid);
            end
            ENG_BODY: begin
                push           = !fifo_full;
                push_flit.data = make_payload(info_q.proto, seq_q);
            end
            default: begin
                push             = !fifo_full;
                push_flit.eop    = 1'b1;
                push_flit.data   = FLIT_W'(stamp_q);
                done_vec[flow_q] = !fifo_full;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            flow_q  <= '0;
            info_q  <= '0;
            stamp_q <= '0;
            left_q  <= '0;
            seq_q   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (any_req) begin
                        flow_q  <= sel_idx;
                        info_q  <= sel_info;
                        stamp_q <= sel_stamp;
                        left_q  <= eff_size(sel_info.size) - SIZE_W'(2);
                        seq_q   <= SIZE_W'(1);
                        state_q <= ENG_HEAD;
                    end
                end
                ENG_HEAD: begin
                    if (push) begin
                        state_q <= (left_q != '0) ? ENG_BODY : ENG_TAIL;
                    end
                end
                ENG_BODY: begin
                    if (push) begin
                        seq_q  <= seq_q + 1'b1;
                        left_q <= left_q - 1'b1;
                        if (left_q == SIZE_W'(1)) begin
                            state_q <= ENG_TAIL;
                        end
                    end
                end
                default: begin
                    if (push) begin
                        state_q <= ENG_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ntg_flit_fifo.sv
module ntg_flit_fifo
    import ntg_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  flit_t in_flit,
    output logic  full,
    input  logic  pop_ready,
    output logic  out_valid,
    output flit_t out_flit
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    flit_t          mem [DEPTH];
    logic [AW-1:0]  wr_q;
    logic [AW-1:0]  rd_q;
    logic [CW-1:0]  cnt_q;
    logic           wr_en;
    logic           rd_en;

    assign full      = (cnt_q == CW'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign wr_en     = push && !full;
    assign rd_en     = out_valid && pop_ready;
    assign out_flit  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_q] <= in_flit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wr_q <= wr_q + 1'b1;
            if (rd_en) rd_q <= rd_q + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/noc_traffic_gen.sv
module noc_traffic_gen
    import ntg_pkg::*;
#(
    parameter int                NUM_FLOWS  = 4,
    parameter int                FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] SRC_ADDR   = 8'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_shift_en,
    input  logic              cfg_sin,
    output logic              cfg_sout,
    output logic              link_valid,
    input  logic              link_ready,
    output logic [FLIT_W-1:0] link_data,
    output logic              link_bop,
    output logic              link_eop
);

    localparam int IW = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1;

    logic [TIME_W-1:0]    gcc_q;
    logic [NUM_FLOWS:0]   chain;
    logic [NUM_FLOWS-1:0] flow_req;
    logic [NUM_FLOWS-1:0] grant_vec;
    logic [NUM_FLOWS-1:0] done_vec;
    logic [TIME_W-1:0]    stamps [NUM_FLOWS];
    pkt_info_t            infos  [NUM_FLOWS];
    logic [IW-1:0]        grant_idx;
    logic                 any_req;
    logic                 accept;
    logic                 push;
    logic                 fifo_full;
    flit_t                push_flit;
    flit_t                out_flit;

    always_ff @(posedge clk) begin
        if (rst || cfg_shift_en) begin
            gcc_q <= '0;
        end else begin
            gcc_q <= gcc_q + 1'b1;
        end
    end

    assign chain[NUM_FLOWS] = cfg_sin;
    assign cfg_sout         = chain[0];

    for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_slot
        ntg_flow_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .shift_en (cfg_shift_en),
            .sin      (chain[i+1]),
            .sout     (chain[i]),
            .gcc      (gcc_q),
            .done     (done_vec[i]),
            .req      (flow_req[i]),
            .stamp    (stamps[i]),
            .info     (infos[i])
        );
    end

    ntg_rr_arbiter #(
        .N  (NUM_FLOWS),
        .IW (IW)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (flow_req),
        .advance   (accept),
        .grant     (grant_vec),
        .grant_idx (grant_idx),
        .any       (any_req)
    );

    ntg_pkt_engine #(
        .N        (NUM_FLOWS),
        .IW       (IW),
        .SRC_ADDR (SRC_ADDR)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .any_req   (any_req),
        .sel_idx   (grant_idx),
        .sel_info  (infos[grant_idx]),
        .sel_stamp (stamps[grant_idx]),
        .fifo_full (fifo_full),
        .accept    (accept),
        .push      (push),
        .push_flit (push_flit),
        .done_vec  (done_vec)
    );

    ntg_flit_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .in_flit   (push_flit),
        .full      (fifo_full),
        .pop_ready (link_ready),
        .out_valid (link_valid),
        .out_flit  (out_flit)
    );

    assign link_data = out_flit.data;
    assign link_bop  = out_flit.bop;
    assign link_eop  = out_flit.eop;

endmodule

// File: rtl/ntg_checker.sv
module ntg_checker
    import ntg_pkg::*;
#(
    parameter int N = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              shift_en,
    input logic [TIME_W-1:0] gcc,
    input logic [N-1:0]      req,
    input logic [N-1:0]      grant,
    input logic              link_valid,
    input logic              link_ready,
    input logic [FLIT_W-1:0] link_data,
    input logic              link_bop,
    input logic              link_eop
);

    // R1
    gcc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (gcc == '0));

    // R1
    gcc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> (gcc == $past(gcc) + 1'b1));

    // R3
    no_req_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |-> (req == '0));

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R4
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R9
    link_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (link_valid && !link_ready) |=>
            (link_valid && $stable(link_data) && $stable(link_bop) && $stable(link_eop)));

    // R5
    marker_excl_chk: assert property (@(posedge clk) disable iff (rst)
        link_valid |-> !(link_bop && link_eop));

endmodule

bind noc_traffic_gen ntg_checker #(.N(NUM_FLOWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (cfg_shift_en),
    .gcc        (gcc_q),
    .req        (flow_req),
    .grant      (grant_vec),
    .link_valid (link_valid),
    .link_ready (link_ready),
    .link_data  (link_data),
    .link_bop   (link_bop),
    .link_eop   (link_eop)
);

// File: tb/noc_traffic_gen_bench.sv
`timescale 1ns/1ps
module noc_traffic_gen_bench;
    import ntg_pkg::*;

    localparam int NF    = 4;
    localparam int IMG_W = NF * DESC_W;
    localparam logic [7:0] SRC = 8'h05;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_shift_en = 1'b0;
    logic        cfg_sin = 1'b0;
    logic        cfg_sout;
    logic        link_valid;
    logic        link_ready;
    logic [31:0] link_data;
    logic        link_bop;
    logic        link_eop;

    int     n_cmp = 0;
    int     n_bad = 0;
    longint tnow  = 0;
    bit     rnd_ready = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    bit     done_flag = 1'b0;

    logic [31:0] q_data [$];
    bit          q_bop  [$];
    bit          q_eop  [$];
    longint      q_stamp[$];

    flow_desc_t cfg [NF];

    bit          prev_hold = 1'b0;
    logic [31:0] prev_data = '0;

    always #5 clk = ~clk;

    noc_traffic_gen u_noc_traffic_gen (
        .clk          (clk),
        .rst          (rst),
        .cfg_shift_en (cfg_shift_en),
        .cfg_sin      (cfg_sin),
        .cfg_sout     (cfg_sout),
        .link_valid   (link_valid),
        .link_ready   (link_ready),
        .link_data    (link_data),
        .link_bop     (link_bop),
        .link_eop     (link_eop)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent cycle counter from R1: counts clocks since shifting stopped.
    always @(posedge clk) begin
        if (rst || cfg_shift_en) tnow <= 0;
        else                     tnow <= tnow + 1;
    end

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        link_ready = rnd_ready ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // Compare every transfer on the clock it occurs against the model's stream.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_hold) begin
                check(link_valid && (link_data == prev_data), "R9 held flit", link_data, prev_data);
            end
            prev_hold = link_valid && !link_ready;
            prev_data = link_data;
            if (link_valid && link_ready) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R3 R8 unexpected flit", link_data, 0);
                end else begin
                    logic [31:0] ed;
                    bit eb, ee;
                    string tag;
                    ed = q_data.pop_front();
                    eb = q_bop.pop_front();
                    ee = q_eop.pop_front();
                    tag = eb ? "R5 R4 header" : (ee ? "R7 R8 trailer" : "R6 payload");
                    check(link_data == ed && link_bop == eb && link_eop == ee,
                          tag, {link_bop, link_eop, link_data}, {eb, ee, ed});
                    if (eb) begin
                        longint st;
                        st = q_stamp.pop_front();
                        check(tnow >= st, "R1 R3 sent before due", tnow, st);
                    end
                end
            end
        end
    end

    // Behavioural time-stepped model: engine takes size+1 cycles per packet.
    task automatic run_model();
        int     cnt [NF];
        longint ns  [NF];
        int     last = NF - 1;
        longint t = 0;
        int     left = 0;
        for (int i = 0; i < NF; i++) begin
            cnt[i] = int'(cfg[i].count);
            ns[i]  = 0;
            left  += cnt[i];
        end
        while (left > 0 && t < 100000) begin
            int pick = -1;
            for (int k = 1; k <= NF; k++) begin
                int c = (last + k) % NF;
                if (pick < 0 && cnt[c] > 0 && ns[c] <= t) pick = c;
            end
            if (pick < 0) begin
                t++;
            end else begin
                int sz = (cfg[pick].size < 2) ? 2 : int'(cfg[pick].size);
                q_data.push_back({cfg[pick].dest, SRC, cfg[pick].bw, cfg[pick].fid, 5'b0});
                q_bop.push_back(1'b1); q_eop.push_back(1'b0);
                q_stamp.push_back(ns[pick]);
                for (int j = 1; j <= sz - 2; j++) begin
                    q_data.push_back({cfg[pick].proto, 13'b0, 10'(j)});
                    q_bop.push_back(1'b0); q_eop.push_back(1'b0);
                end
                q_data.push_back(32'(ns[pick]));
                q_bop.push_back(1'b0); q_eop.push_back(1'b1);
                ns[pick] += sz + int'(cfg[pick].gap);
                cnt[pick]--;
                left--;
                last = pick;
                t += sz + 1;
            end
        end
    endtask

    function automatic logic [IMG_W-1:0] image();
        logic [IMG_W-1:0] img;
        for (int i = 0; i < NF; i++) img[(NF-1-i)*DESC_W +: DESC_W] = cfg[i];
        return img;
    endfunction

    task automatic set_flow(input int i, input int bw, input int fid, input int proto,
                            input int dest, input int count, input int size, input int gap);
        cfg[i].bw    = 7'(bw);
        cfg[i].fid   = 4'(fid);
        cfg[i].proto = 9'(proto);
        cfg[i].dest  = 8'(dest);
        cfg[i].count = 20'(count);
        cfg[i].size  = 10'(size);
        cfg[i].gap   = 12'(gap);
    endtask

    // Shift a stream MSB first; optionally compare cfg_sout with an expected stream.
    task automatic shift_stream(input logic [2*IMG_W-1:0] s, input int nbits,
                                input bit cmp, input logic [2*IMG_W-1:0] exp_out);
        for (int j = nbits - 1; j >= 0; j--) begin
            @(posedge clk); #1;
            cfg_shift_en = 1'b1;
            cfg_sin = s[j];
            if (cmp) check(cfg_sout == exp_out[j], "R2 serial out", cfg_sout, exp_out[j]);
        end
        check(link_valid == 1'b0, "R3 no traffic while shifting", link_valid, 0);
        @(posedge clk); #1;
        cfg_shift_en = 1'b0;
    endtask

    task automatic drain_and_idle(input string tag);
        int guard = 0;
        while (q_data.size() != 0 && guard < 20000) begin
            @(posedge clk); guard++;
        end
        check(q_data.size() == 0, {tag, " stream complete"}, q_data.size(), 0);
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(link_valid == 1'b0, {tag, " R8 silent after count exhausted"}, link_valid, 0);
    endtask

    initial begin
        logic [IMG_W-1:0]   img_a;
        logic [IMG_W-1:0]   img_b;
        logic [2*IMG_W-1:0] expo;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(link_valid == 1'b0, "R9 reset valid", link_valid, 0);
        check(cfg_sout == 1'b0, "R2 reset sout", cfg_sout, 0);

        // Pattern A: arbitrary bits, including non-zero counts.
        for (int b = 0; b < IMG_W; b++) img_a[b] = (((b * 13 + 5) % 7) < 3);

        // Pattern B: mixed sizes and gaps so readiness and round-robin interact.
        set_flow(0, 25, 1, 9'h1A5, 8'h12, 3, 4, 3);
        set_flow(1, 50, 2, 9'h033, 8'h34, 2, 1, 0);
        set_flow(2, 100, 3, 9'h0F0, 8'h56, 2, 6, 20);
        set_flow(3, 10, 4, 9'h111, 8'h78, 0, 3, 1);
        img_b = image();

        // R2: zeros from reset come out during A; A comes out during B.
        expo = {{IMG_W{1'b0}}, img_a};
        run_model();
        shift_stream({img_a, img_b}, 2 * IMG_W, 1'b1, expo);
        drain_and_idle("main");

        // Backpressure with one active flow (R9, R6, R8).
        set_flow(0, 1, 0, 0, 0, 0, 2, 0);
        set_flow(1, 77, 9, 9'h1FF, 8'hC3, 3, 5, 2);
        set_flow(2, 1, 0, 0, 0, 0, 2, 0);
        set_flow(3, 1, 0, 0, 0, 0, 2, 0);
        img_b = image();
        run_model();
        rnd_ready = 1'b1;
        shift_stream({{IMG_W{1'b0}}, img_b}, IMG_W, 1'b0, '0);
        drain_and_idle("backpressure");
        rnd_ready = 1'b0;

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule